// File: doc/BRIEF.md
# Clock-Stretch Bus Timeout Watchdog

This block guards a serial bus against a target that holds the clock line low indefinitely. While the bus engine reports that the clock is being stretched and the timeout function is enabled, a 14-bit counter advances. When that counter wraps from all ones back to zero, a sticky timeout flag is raised. An optional prescaler lets the counter advance only once in every four system clocks, which makes the timeout window four times longer.

Software clears the flag with a write-one-to-clear strobe. An interrupt request follows the flag whenever the interrupt enable is high. The counter and the prescaler return to zero as soon as stretching stops or the enable drops, so only an unbroken stretch can trigger a timeout. After an expiry the counter stays at zero until the stretch ends and a new one begins. This means one long stretch raises the flag only once.

Top module: `stretch_timeout`

## Requirements
- R1: With the divide option low, the flag rises after exactly 2^14 consecutive clocks in which the enable and the stretch indication are both high, and not after 2^14-1 such clocks.
- R2: No counting takes place while the enable is low, even if the stretch indication is high.
- R3: With the divide option high, the flag rises after exactly 4*2^14 consecutive enabled stretch clocks, and not one clock earlier.
- R4: A clock with the stretch indication low returns both the counter and the prescaler to zero, so a later stretch needs a full window.
- R5: A clock with the enable low also returns the counter and the prescaler to zero.
- R6: After an expiry, a stretch that continues does not raise the flag again until it has ended and restarted.
- R7: The flag is sticky. A clear strobe of 1 drops it at the next clock edge, and a clear strobe of 0 leaves it unchanged.
- R8: When an expiry and a clear strobe fall in the same clock, the flag ends up set.
- R9: The interrupt request equals the flag while the interrupt enable is high and is 0 otherwise, and it follows both of them combinationally.
- R10: After reset, the flag and the interrupt request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_en | input | 1 | Enables the timeout counter |
| div4_sel | input | 1 | 1 = counter advances once every four clocks |
| stretch_active | input | 1 | 1 while the bus engine holds the clock stretched |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt enable |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Interrupt request |

## Verification
The flag is registered. It changes on the clock edge that ends the last counted cycle, or on the edge that ends a clear strobe. So after an input pattern has been held for N rising edges, the bench samples the flag at the next falling edge. The interrupt request is combinational from the flag and the enable, so the bench samples it a short delay after it changes the enable, with no clock edge in between. Each stimulus row gives the number of edges over which it is held. Boundary rows stop exactly one edge before an expiry and then add a single edge, so an off-by-one error in the counter or the prescaler shows up in one sample.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam int unsigned TMO_CNT_W_DEF   = 14;
    localparam int unsigned TMO_PRE_DIV_DEF = 4;

    // Per-cycle advance request passed from the gating/prescale stage to the counter.
    typedef struct packed {
        logic run;   // enable and stretch both high this cycle
        logic tick;  // counter may advance on this edge
    } tmo_step_t;
endpackage

// File: rtl/tmo_prescale.sv
module tmo_prescale #(
    parameter int unsigned RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_sel,
    output logic tick
);
    localparam int unsigned PW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || !div_sel) begin
            st_d.phase = '0;
        end else if (st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
        tick = run && (!div_sel || (st_q.phase == LAST));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter
    import tmo_pkg::*;
#(
    parameter int unsigned CNT_W = TMO_CNT_W_DEF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tmo_step_t step,
    output logic      expire
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             spent;  // window expired in this stretch; hold at zero
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (!step.run) begin
            st_d.cnt   = '0;
            st_d.spent = 1'b0;
        end else if (step.tick && !st_q.spent) begin
            if (st_q.cnt == TOP) begin
                st_d.cnt   = '0;
                st_d.spent = 1'b1;
                expire     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.flag = 1'b1;          // hardware set has priority
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
        flag = st_q.flag;
        irq  = st_q.flag && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stretch_timeout.sv
module stretch_timeout
    import tmo_pkg::*;
#(
    parameter int unsigned CNT_W     = TMO_CNT_W_DEF,
    parameter int unsigned PRE_RATIO = TMO_PRE_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_en,
    input  logic div4_sel,
    input  logic stretch_active,
    input  logic flag_clr,
    input  logic irq_en,
    output logic tmo_flag,
    output logic tmo_irq
);
    tmo_step_t step;
    logic      pre_tick;
    logic      cnt_expire;

    assign step.run  = tmo_en && stretch_active;
    assign step.tick = pre_tick;

    generate
        if (PRE_RATIO > 1) begin : g_pre
            tmo_prescale #(.RATIO(PRE_RATIO)) u_pre (
                .clk     (clk),
                .rst_n   (rst_n),
                .run     (step.run),
                .div_sel (div4_sel),
                .tick    (pre_tick)
            );
        end else begin : g_nopre
            assign pre_tick = step.run;
        end
    endgenerate

    tmo_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .expire (cnt_expire)
    );

    tmo_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (cnt_expire),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (tmo_flag),
        .irq    (tmo_irq)
    );
endmodule

// File: rtl/stretch_timeout_chk.sv
module stretch_timeout_chk (
    input logic clk,
    input logic rst_n,
    input logic tmo_en,
    input logic stretch_active,
    input logic flag_clr,
    input logic irq_en,
    input logic tmo_flag,
    input logic tmo_irq,
    input logic cnt_expire
);
    p_rise_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(tmo_en && stretch_active));

    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cnt_expire) |=> !tmo_flag);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !flag_clr) |=> tmo_flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_expire |=> tmo_flag);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !tmo_irq);

    p_irq_from_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> tmo_flag);

    p_no_expire_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stretch_active |-> !cnt_expire);
endmodule

bind stretch_timeout stretch_timeout_chk u_chk (.*);

// File: tb/stretch_timeout_tb.sv
module stretch_timeout_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tmo_en = 1'b0, div4_sel = 1'b0, stretch_active = 1'b0;
    logic flag_clr = 1'b0, irq_en = 1'b0;
    logic tmo_flag, tmo_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    stretch_timeout u_dut (
        .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .div4_sel(div4_sel),
        .stretch_active(stretch_active), .flag_clr(flag_clr), .irq_en(irq_en),
        .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
    );

    typedef struct packed {
        logic        en;
        logic        d4;
        logic        st;
        logic        ie;
        logic        clr;
        int unsigned cyc;
        logic        ef;
        logic        ei;
        int unsigned req;
    } row_t;

    localparam int NROWS = 19;
    localparam row_t TBL [NROWS] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 16383, 1'b0,1'b0, 1},  // R1 one short
        '{1'b1,1'b0,1'b1,1'b0,1'b0,     1, 1'b1,1'b0, 1},  // R1 expiry, irq masked
        '{1'b1,1'b0,1'b0,1'b1,1'b0,     1, 1'b1,1'b1, 9},  // R9 irq follows flag; R7 sticky
        '{1'b1,1'b0,1'b0,1'b1,1'b1,     1, 1'b0,1'b0, 7},  // R7 clear
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 16383, 1'b0,1'b0, 2},  // R2 disabled stretch
        '{1'b1,1'b0,1'b1,1'b1,1'b0,     1, 1'b0,1'b0, 2},  // R2 would expire if counted
        '{1'b1,1'b0,1'b1,1'b1,1'b0,   100, 1'b0,1'b0, 4},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,     1, 1'b0,1'b0, 4},  // R4 stretch ends
        '{1'b1,1'b0,1'b1,1'b1,1'b0, 16383, 1'b0,1'b0, 4},  // R4 full window needed
        '{1'b1,1'b0,1'b1,1'b1,1'b0,     1, 1'b1,1'b1, 4},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,     1, 1'b0,1'b0, 7},  // R7 clear during stretch
        '{1'b1,1'b0,1'b1,1'b1,1'b0, 17000, 1'b0,1'b0, 6},  // R6 hold after expiry
        '{1'b1,1'b0,1'b0,1'b1,1'b0,     1, 1'b0,1'b0, 6},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,   100, 1'b0,1'b0, 5},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,     1, 1'b0,1'b0, 5},  // R5 enable dropped
        '{1'b1,1'b0,1'b1,1'b1,1'b0, 16383, 1'b0,1'b0, 5},  // R5 full window needed
        '{1'b1,1'b0,1'b1,1'b1,1'b1,     1, 1'b1,1'b1, 8},  // R8 set beats clear
        '{1'b1,1'b1,1'b1,1'b1,1'b0, 65535, 1'b0,1'b0, 3},  // R3 one short (after clear row)
        '{1'b1,1'b1,1'b1,1'b1,1'b0,     1, 1'b1,1'b1, 3}   // R3 expiry
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", tmo_flag, 1'b0, "flag in reset");
        check("R10", tmo_irq, 1'b0, "irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", tmo_flag, 1'b0, "flag after reset");

        for (int i = 0; i < NROWS; i++) begin
            // A clear strobe before the R3 rows empties the flag set by the R8 row.
            if (i == 17) begin
                stretch_active = 1'b0;
                flag_clr = 1'b1;
                @(posedge clk);
                @(negedge clk);
                flag_clr = 1'b0;
                check("R7", tmo_flag, 1'b0, "clear before div4 run");
            end
            tmo_en = TBL[i].en;
            div4_sel = TBL[i].d4;
            stretch_active = TBL[i].st;
            irq_en = TBL[i].ie;
            flag_clr = TBL[i].clr;
            repeat (TBL[i].cyc) @(posedge clk);
            @(negedge clk);
            flag_clr = 1'b0;
            check($sformatf("R%0d row%0d", TBL[i].req, i), tmo_flag, TBL[i].ef, "flag");
            check($sformatf("R%0d row%0d", TBL[i].req, i), tmo_irq, TBL[i].ei, "irq");
        end

        // Directed: R9 irq follows enable without a clock edge
        stretch_active = 1'b0;
        irq_en = 1'b0;
        #1;
        check("R9", tmo_irq, 1'b0, "irq masked combinationally");
        irq_en = 1'b1;
        #1;
        check("R9", tmo_irq, 1'b1, "irq unmasked combinationally");

        // Directed: R7 clear strobe of zero has no effect
        @(negedge clk);
        flag_clr = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R7", tmo_flag, 1'b1, "zero clear keeps flag");

        // Directed: R10 reset clears a set flag
        rst_n = 1'b0;
        #1;
        check("R10", tmo_flag, 1'b0, "flag cleared by reset");
        check("R10", tmo_irq, 1'b0, "irq cleared by reset");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule